// File: doc/BRIEF.md
# AXI transaction order monitor

This block watches one AXI master interface without driving any of the bus signals. It follows the read address, write address, write data, write response and read data channels. For each direction it records every accepted request in a small table, grouped by transaction ID. It uses those records to judge whether each returning response is one the master can legally receive. It also compares every write burst against the length declared on its write address, which catches the two length mismatches that can hang a slave or a master.

Every violation produces a trace record. A record holds a 3-bit error code, the transaction ID involved and a 16-bit cycle timestamp, and it is offered on a valid/ready output. The monitor has no path back to the bus, so it never stalls the traffic it observes. If the trace consumer is slow, records are dropped rather than the bus being held.

Top module: `axi_order_monitor`

## Requirements
- R1: After reset, trc_valid is low and no transaction is outstanding in either direction.
- R2: Every accepted request is recorded under its ID. Each ID has a pending flag and a count of outstanding requests. Responses with the same ID retire those requests oldest first. A response that matches an outstanding request produces no record. A read request retires on its last data beat (r_last high). A write request retires on its write response.
- R3: A write response whose ID has no outstanding write produces a record with code 1 and that ID.
- R4: Any read data beat whose ID has no outstanding read produces a record with code 2 and that ID. The read IDs and the write IDs are tracked independently.
- R5: If w_last arrives on beat k (counted from 1) with k < len+1, where len is the burst's write-address length field, a record with code 3 and the burst's write ID is produced on that beat.
- R6: A burst that carries more than len+1 beats produces one record with code 4 and the burst's write ID. The record comes on beat len+2 only, and the burst ends at its w_last.
- R7: A request that arrives while its direction's table holds TBL_DEPTH entries produces a record with code 5 and the request ID. The request is not recorded, so its later response counts as unmatched.
- R8: With timeout_limit = N > 0, an entry that is still outstanding N cycles after the cycle in which it was recorded produces one record with code 6 and its ID. The record becomes visible N+1 cycles after the request handshake. With N = 0 no timeout is reported.
- R9: A record stays stable while trc_valid is high and trc_ready is low. Violations that occur while the record is held are dropped. When several violations occur in one cycle, only the one with the lowest code is kept.
- R10: trc_time is a free-running cycle count taken in the cycle of the violation. The timestamps of two records differ by exactly the number of cycles between their violations.
- R11: Write data beats that arrive while no write burst length is queued are ignored. They produce no record and do not disturb the check of later bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| timeout_limit | input | AGE_W | Outstanding-cycle limit; 0 disables the timeout |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_id | input | ID_W | Write address ID |
| aw_len | input | LEN_W | Write burst length minus one |
| w_valid | input | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_last | input | 1 | Last write beat marker |
| b_valid | input | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_id | input | ID_W | Write response ID |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_id | input | ID_W | Read address ID |
| r_valid | input | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_id | input | ID_W | Read data ID |
| r_last | input | 1 | Last read beat marker |
| trc_valid | output | 1 | Trace record valid |
| trc_ready | input | 1 | Trace consumer ready |
| trc_code | output | 3 | Error code: 1 write order, 2 read order, 3 short burst, 4 long burst, 5 table overflow, 6 timeout |
| trc_id | output | ID_W | Transaction ID of the violation |
| trc_time | output | TS_W | Cycle timestamp of the violation |

## Verification
Unmatched responses are swept over every ID in both directions. This shows that the two tables stay separate and that the reported ID follows the response. Same-ID groups of one to three reads are retired, and one extra response is then sent. This separates correct per-ID counting from a flag that clears too early or too late. The burst check is swept over every length from 0 to 3 against every beat count from 1 to len+3. That sweep tells short, exact and long bursts apart and confirms the single long record. Further cases cover a full table, exact timeout cycles, a disabled timeout, collisions between simultaneous violations, back-pressure on the trace output, and the spacing between timestamps.

// File: rtl/axom_pkg.sv
package axom_pkg;
  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_WR_ORDER = 3'd1,
    ERR_RD_ORDER = 3'd2,
    ERR_SHORT    = 3'd3,
    ERR_LONG     = 3'd4,
    ERR_OVERFLOW = 3'd5,
    ERR_TIMEOUT  = 3'd6
  } err_code_e;
endpackage

// File: rtl/axom_id_tracker.sv
module axom_id_tracker #(
  parameter int ID_W  = 4,
  parameter int DEPTH = 8,
  parameter int AGE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [ID_W-1:0]  alloc_id,
  input  logic             rsp,
  input  logic             rsp_last,
  input  logic [ID_W-1:0]  rsp_id,
  input  logic [AGE_W-1:0] age_limit,
  output logic             ord_err,
  output logic             ovf_err,
  output logic             to_err,
  output logic [ID_W-1:0]  to_id
);
  localparam int NID   = 1 << ID_W;
  localparam int RK_W  = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] ent_vld, ent_vld_d, ent_done, ent_done_d;
  logic [ID_W-1:0]  ent_id   [DEPTH];
  logic [RK_W-1:0]  ent_rank [DEPTH];
  logic [RK_W-1:0]  ent_rank_d [DEPTH];
  logic [AGE_W-1:0] ent_age  [DEPTH];
  logic [AGE_W-1:0] ent_age_d [DEPTH];
  logic [RK_W-1:0]  id_cnt   [NID];
  logic [RK_W-1:0]  id_cnt_d [NID];
  logic [NID-1:0]   id_flag, id_flag_d;

  logic             full, do_alloc, do_ret;
  logic [IDX_W-1:0] free_idx, to_sel;
  logic [DEPTH-1:0] head_hit, to_hit;
  logic [RK_W-1:0]  new_rank;

  always_comb begin
    full     = &ent_vld;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!ent_vld[i]) free_idx = IDX_W'(i);
    ovf_err  = alloc && full;
    do_alloc = alloc && !full;
    ord_err  = rsp && !id_flag[rsp_id];
    do_ret   = rsp && rsp_last && id_flag[rsp_id];
    new_rank = id_cnt[alloc_id] - ((do_ret && (rsp_id == alloc_id)) ? RK_W'(1) : RK_W'(0));
    for (int i = 0; i < DEPTH; i++) begin
      head_hit[i] = ent_vld[i] && (ent_id[i] == rsp_id) && (ent_rank[i] == '0);
      to_hit[i]   = ent_vld[i] && !ent_done[i] && (age_limit != '0) && (ent_age[i] >= age_limit);
    end
    to_sel = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (to_hit[i]) to_sel = IDX_W'(i);
    to_err = |to_hit;
    to_id  = ent_id[to_sel];
  end

  always_comb begin
    ent_vld_d  = ent_vld;
    ent_done_d = ent_done;
    for (int i = 0; i < DEPTH; i++) begin
      ent_rank_d[i] = ent_rank[i];
      ent_age_d[i]  = ent_age[i];
      if (ent_vld[i] && !ent_done[i] && (ent_age[i] != '1))
        ent_age_d[i] = ent_age[i] + AGE_W'(1);
      if (to_err && (to_sel == IDX_W'(i)))
        ent_done_d[i] = 1'b1;
      if (do_ret && ent_vld[i] && (ent_id[i] == rsp_id)) begin
        if (ent_rank[i] == '0) ent_vld_d[i] = 1'b0;
        else                   ent_rank_d[i] = ent_rank[i] - RK_W'(1);
      end
      if (do_alloc && (free_idx == IDX_W'(i))) begin
        ent_vld_d[i]  = 1'b1;
        ent_done_d[i] = 1'b0;
        ent_rank_d[i] = new_rank;
        ent_age_d[i]  = '0;
      end
    end
    for (int j = 0; j < NID; j++) begin
      id_cnt_d[j] = id_cnt[j]
                  + ((do_alloc && (alloc_id == ID_W'(j))) ? RK_W'(1) : RK_W'(0))
                  - ((do_ret && (rsp_id == ID_W'(j))) ? RK_W'(1) : RK_W'(0));
      id_flag_d[j] = (id_cnt_d[j] != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_vld  <= '0;
      ent_done <= '0;
      id_flag  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        ent_id[i]   <= '0;
        ent_rank[i] <= '0;
        ent_age[i]  <= '0;
      end
      for (int j = 0; j < NID; j++) id_cnt[j] <= '0;
    end else begin
      ent_vld  <= ent_vld_d;
      ent_done <= ent_done_d;
      id_flag  <= id_flag_d;
      for (int i = 0; i < DEPTH; i++) begin
        ent_rank[i] <= ent_rank_d[i];
        ent_age[i]  <= ent_age_d[i];
      end
      for (int j = 0; j < NID; j++) id_cnt[j] <= id_cnt_d[j];
      if (do_alloc) ent_id[free_idx] <= alloc_id;
    end
  end

  AST_ALLOC_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    do_alloc |=> id_flag[$past(alloc_id)]); // R2
  AST_ONE_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp && rsp_last && id_flag[rsp_id]) |-> $onehot(head_hit)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ($countones(ent_vld) <= $past($countones(ent_vld)))); // R7
endmodule

// File: rtl/axom_wlen_check.sv
module axom_wlen_check #(
  parameter int ID_W  = 4,
  parameter int LEN_W = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             aw_fire,
  input  logic [ID_W-1:0]  aw_id,
  input  logic [LEN_W-1:0] aw_len,
  input  logic             w_fire,
  input  logic             w_last,
  output logic             short_err,
  output logic             long_err,
  output logic [ID_W-1:0]  err_id
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int BT_W  = LEN_W + 1;

  logic [LEN_W-1:0] len_q [DEPTH];
  logic [ID_W-1:0]  id_q  [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_ptr_d, rd_ptr_d;
  logic [CNT_W-1:0] q_cnt, q_cnt_d;
  logic [BT_W-1:0]  beat, beat_d;
  logic             q_empty, push, pop, beat_en;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    q_empty   = (q_cnt == '0);
    push      = aw_fire && (q_cnt != CNT_W'(DEPTH));
    beat_en   = w_fire && !q_empty;
    pop       = beat_en && w_last;
    err_id    = id_q[rd_ptr];
    short_err = pop && (beat < {1'b0, len_q[rd_ptr]});
    long_err  = beat_en && (beat == ({1'b0, len_q[rd_ptr]} + BT_W'(1)));
    wr_ptr_d  = push ? nxt(wr_ptr) : wr_ptr;
    rd_ptr_d  = pop ? nxt(rd_ptr) : rd_ptr;
    q_cnt_d   = q_cnt + (push ? CNT_W'(1) : CNT_W'(0)) - (pop ? CNT_W'(1) : CNT_W'(0));
    beat_d    = beat;
    if (pop)                     beat_d = '0;
    else if (beat_en && beat != '1) beat_d = beat + BT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      q_cnt  <= '0;
      beat   <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        len_q[i] <= '0;
        id_q[i]  <= '0;
      end
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      q_cnt  <= q_cnt_d;
      beat   <= beat_d;
      if (push) begin
        len_q[wr_ptr] <= aw_len;
        id_q[wr_ptr]  <= aw_id;
      end
    end
  end

  AST_LONG_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    long_err |=> !long_err); // R6
  AST_SHORT_NEEDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    short_err |=> (q_cnt <= $past(q_cnt))); // R5
endmodule

// File: rtl/axi_order_monitor.sv
module axi_order_monitor
  import axom_pkg::*;
#(
  parameter int ID_W      = 4,
  parameter int LEN_W     = 8,
  parameter int TBL_DEPTH = 8,
  parameter int LQ_DEPTH  = 8,
  parameter int AGE_W     = 16,
  parameter int TS_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AGE_W-1:0] timeout_limit,
  input  logic             aw_valid,
  input  logic             aw_ready,
  input  logic [ID_W-1:0]  aw_id,
  input  logic [LEN_W-1:0] aw_len,
  input  logic             w_valid,
  input  logic             w_ready,
  input  logic             w_last,
  input  logic             b_valid,
  input  logic             b_ready,
  input  logic [ID_W-1:0]  b_id,
  input  logic             ar_valid,
  input  logic             ar_ready,
  input  logic [ID_W-1:0]  ar_id,
  input  logic             r_valid,
  input  logic             r_ready,
  input  logic [ID_W-1:0]  r_id,
  input  logic             r_last,
  output logic             trc_valid,
  input  logic             trc_ready,
  output logic [2:0]       trc_code,
  output logic [ID_W-1:0]  trc_id,
  output logic [TS_W-1:0]  trc_time
);
  logic [1:0]      rst_sync;
  logic            rst_i;
  logic [TS_W-1:0] ts;
  logic            aw_fire, w_fire, b_fire, ar_fire, r_fire;
  logic            w_ord, w_ovf, w_to, r_ord, r_ovf, r_to, sh_err, lg_err;
  logic [ID_W-1:0] w_to_id, r_to_id, bl_id;
  err_code_e       code_d;
  logic [ID_W-1:0] id_d;
  logic            load, valid_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  assign aw_fire = aw_valid && aw_ready;
  assign w_fire  = w_valid && w_ready;
  assign b_fire  = b_valid && b_ready;
  assign ar_fire = ar_valid && ar_ready;
  assign r_fire  = r_valid && r_ready;

  axom_id_tracker #(.ID_W(ID_W), .DEPTH(TBL_DEPTH), .AGE_W(AGE_W)) u_wr_trk (
    .clk(clk), .rst_n(rst_i), .alloc(aw_fire), .alloc_id(aw_id),
    .rsp(b_fire), .rsp_last(1'b1), .rsp_id(b_id), .age_limit(timeout_limit),
    .ord_err(w_ord), .ovf_err(w_ovf), .to_err(w_to), .to_id(w_to_id));

  axom_id_tracker #(.ID_W(ID_W), .DEPTH(TBL_DEPTH), .AGE_W(AGE_W)) u_rd_trk (
    .clk(clk), .rst_n(rst_i), .alloc(ar_fire), .alloc_id(ar_id),
    .rsp(r_fire), .rsp_last(r_last), .rsp_id(r_id), .age_limit(timeout_limit),
    .ord_err(r_ord), .ovf_err(r_ovf), .to_err(r_to), .to_id(r_to_id));

  axom_wlen_check #(.ID_W(ID_W), .LEN_W(LEN_W), .DEPTH(LQ_DEPTH)) u_wlen (
    .clk(clk), .rst_n(rst_i), .aw_fire(aw_fire), .aw_id(aw_id), .aw_len(aw_len),
    .w_fire(w_fire), .w_last(w_last), .short_err(sh_err), .long_err(lg_err),
    .err_id(bl_id));

  always_comb begin
    code_d = ERR_NONE;
    id_d   = '0;
    if (w_ord)       begin code_d = ERR_WR_ORDER; id_d = b_id;    end
    else if (r_ord)  begin code_d = ERR_RD_ORDER; id_d = r_id;    end
    else if (sh_err) begin code_d = ERR_SHORT;    id_d = bl_id;   end
    else if (lg_err) begin code_d = ERR_LONG;     id_d = bl_id;   end
    else if (w_ovf)  begin code_d = ERR_OVERFLOW; id_d = aw_id;   end
    else if (r_ovf)  begin code_d = ERR_OVERFLOW; id_d = ar_id;   end
    else if (w_to)   begin code_d = ERR_TIMEOUT;  id_d = w_to_id; end
    else if (r_to)   begin code_d = ERR_TIMEOUT;  id_d = r_to_id; end
    load    = (code_d != ERR_NONE) && (!trc_valid || trc_ready);
    valid_d = load || (trc_valid && !trc_ready);
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ts        <= '0;
      trc_valid <= 1'b0;
      trc_code  <= 3'd0;
      trc_id    <= '0;
      trc_time  <= '0;
    end else begin
      ts        <= ts + TS_W'(1);
      trc_valid <= valid_d;
      if (load) begin
        trc_code <= code_d;
        trc_id   <= id_d;
        trc_time <= ts;
      end
    end
  end

  AST_TRACE_HOLD: assert property (@(posedge clk) disable iff (!rst_i)
    (trc_valid && !trc_ready) |=> (trc_valid && $stable(trc_code) && $stable(trc_id) && $stable(trc_time))); // R9
  AST_TRACE_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_i)
    trc_valid |-> ((trc_code != 3'd0) && (trc_code <= 3'd6))); // R9
endmodule

// File: tb/sim_axi_order_monitor.sv
module sim_axi_order_monitor;
  logic clk = 1'b0;
  logic rst_n;
  logic [15:0] timeout_limit;
  logic aw_valid, w_valid, w_last, b_valid, ar_valid, r_valid, r_last, trc_ready;
  logic [1:0] aw_id, b_id, ar_id, r_id;
  logic [7:0] aw_len;
  logic trc_valid;
  logic [2:0] trc_code;
  logic [1:0] trc_id;
  logic [15:0] trc_time;
  integer n_vec = 0;
  integer n_bad = 0;
  logic [15:0] t1;

  always #10 clk = ~clk;

  axi_order_monitor #(.ID_W(2), .LEN_W(8), .TBL_DEPTH(4), .LQ_DEPTH(4), .AGE_W(16), .TS_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .timeout_limit(timeout_limit),
    .aw_valid(aw_valid), .aw_ready(1'b1), .aw_id(aw_id), .aw_len(aw_len),
    .w_valid(w_valid), .w_ready(1'b1), .w_last(w_last),
    .b_valid(b_valid), .b_ready(1'b1), .b_id(b_id),
    .ar_valid(ar_valid), .ar_ready(1'b1), .ar_id(ar_id),
    .r_valid(r_valid), .r_ready(1'b1), .r_id(r_id), .r_last(r_last),
    .trc_valid(trc_valid), .trc_ready(trc_ready), .trc_code(trc_code),
    .trc_id(trc_id), .trc_time(trc_time));

  task automatic chk(input bit ev, input int ec, input int eid, input string tag);
    n_vec++;
    if (trc_valid !== ev || (ev && (trc_code !== 3'(ec) || trc_id !== 2'(eid)))) begin
      n_bad++;
      $display("FAIL %s: got v=%0b code=%0d id=%0d, expected v=%0b code=%0d id=%0d",
               tag, trc_valid, trc_code, trc_id, ev, ec, eid);
    end
  endtask

  task automatic quiet();
    aw_valid = 0; w_valid = 0; w_last = 0; b_valid = 0; ar_valid = 0; r_valid = 0; r_last = 0;
  endtask
  task automatic step(); @(negedge clk); quiet(); endtask
  task automatic p_aw(input int id, input int len);
    aw_valid = 1; aw_id = 2'(id); aw_len = 8'(len); step();
  endtask
  task automatic p_w(input bit last); w_valid = 1; w_last = last; step(); endtask
  task automatic p_b(input int id); b_valid = 1; b_id = 2'(id); step(); endtask
  task automatic p_ar(input int id); ar_valid = 1; ar_id = 2'(id); step(); endtask
  task automatic p_r(input int id, input bit last);
    r_valid = 1; r_id = 2'(id); r_last = last; step();
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    quiet(); aw_id = 0; aw_len = 0; b_id = 0; ar_id = 0; r_id = 0;
    rst_n = 0; trc_ready = 1; timeout_limit = 0;
    repeat (3) @(negedge clk);
    chk(0, 0, 0, "R1 in reset");
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(0, 0, 0, "R1 after reset");

    // R3: unmatched write responses, every ID
    for (int id = 0; id < 4; id++) begin p_b(id); chk(1, 1, id, "R3"); end
    // R4: unmatched read beats, every ID
    for (int id = 0; id < 4; id++) begin p_r(id, 0); chk(1, 2, id, "R4"); end

    // R2: same-ID groups retire in order, one extra response is unmatched
    for (int id = 0; id < 4; id++)
      for (int k = 1; k <= 3; k++) begin
        for (int a = 0; a < k; a++) begin p_ar(id); chk(0, 0, 0, "R2 request"); end
        p_r(id, 0); chk(0, 0, 0, "R2 middle beat");
        for (int a = 0; a < k; a++) begin p_r(id, 1); chk(0, 0, 0, "R2 retire"); end
        p_r(id, 1); chk(1, 2, id, "R2 extra response");
      end
    p_ar(0); p_ar(1); p_r(1, 1); chk(0, 0, 0, "R2 interleave"); p_r(0, 1); chk(0, 0, 0, "R2 interleave");

    // R4: read and write tables independent
    p_ar(3); chk(0, 0, 0, "R4 read open");
    p_b(3); chk(1, 1, 3, "R4 write side unaffected");
    p_r(3, 1); chk(0, 0, 0, "R4 read retire");

    // R5/R6: length sweep
    for (int L = 0; L < 4; L++)
      for (int n = 1; n <= L + 3; n++) begin
        p_aw(L, L); chk(0, 0, 0, "R5 address");
        for (int b = 1; b <= n; b++) begin
          p_w(b == n);
          if (b == n && b < L + 1)  chk(1, 3, L, "R5 short burst");
          else if (b == L + 2)      chk(1, 4, L, "R6 long burst");
          else                      chk(0, 0, 0, "R6 no record");
        end
        p_b(L); chk(0, 0, 0, "R5 retire");
      end

    // R11: stray data beats
    p_w(1); chk(0, 0, 0, "R11 stray last");
    p_w(0); chk(0, 0, 0, "R11 stray beat");
    p_aw(1, 1); p_w(0); chk(0, 0, 0, "R11 later burst");
    p_w(1); chk(0, 0, 0, "R11 later burst end");
    p_b(1); chk(0, 0, 0, "R11 retire");

    // R7: table overflow
    for (int a = 0; a < 4; a++) begin p_ar(1); chk(0, 0, 0, "R7 fill"); end
    p_ar(2); chk(1, 5, 2, "R7 overflow");
    for (int a = 0; a < 4; a++) begin p_r(1, 1); chk(0, 0, 0, "R7 drain"); end
    p_r(2, 1); chk(1, 2, 2, "R7 unrecorded request");

    // R8: timeout exact cycle
    timeout_limit = 5;
    p_ar(0);
    for (int k = 1; k <= 5; k++) begin @(negedge clk); chk(0, 0, 0, "R8 before limit"); end
    @(negedge clk); chk(1, 6, 0, "R8 timeout");
    @(negedge clk); chk(0, 0, 0, "R8 reported once");
    p_r(0, 1); chk(0, 0, 0, "R8 retire");
    timeout_limit = 0;
    p_ar(1);
    repeat (20) @(negedge clk);
    chk(0, 0, 0, "R8 disabled");
    p_r(1, 1); chk(0, 0, 0, "R8 retire");

    // R9: collision keeps lowest code
    b_valid = 1; b_id = 0; r_valid = 1; r_id = 1; r_last = 1; step();
    chk(1, 1, 0, "R9 collision");
    @(negedge clk); chk(0, 0, 0, "R9 loser dropped");
    // R9: hold under back-pressure
    trc_ready = 0;
    p_b(2); chk(1, 1, 2, "R9 held");
    p_r(3, 0); chk(1, 1, 2, "R9 held during new error");
    @(negedge clk); chk(1, 1, 2, "R9 still held");
    trc_ready = 1;
    @(negedge clk); chk(0, 0, 0, "R9 consumed, dropped error gone");

    // R10: timestamp spacing
    p_b(0); chk(1, 1, 0, "R10 first"); t1 = trc_time;
    repeat (3) @(negedge clk);
    p_b(1); chk(1, 1, 1, "R10 second");
    n_vec++;
    if (trc_time - t1 !== 16'd4) begin
      n_bad++;
      $display("FAIL R10: got delta %0d, expected 4", trc_time - t1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule